// File: doc/BRIEF.md
# Memory-Backed FIFO Spill Controller

This block sits between a small on-chip input queue and a small on-chip output queue and carries a stream from producer to consumer in strict order. While the consumer keeps up, each word moves straight from the input queue to the output queue and external memory is never touched. When the output queue is full and the input queue has gathered a whole burst, the controller switches into a spill mode. In that mode it writes fixed-length bursts through an AXI4 master into a region of external memory. It later reads those bursts back, oldest first, as the output queue frees room.

The spill region is a circular buffer that is addressed in whole bursts. In spill mode every new input word takes the memory path until the region is empty again, so no word can overtake older words that are parked in memory. The region size, the word width (given as log2 of the bit count), the burst length and the queue depths are parameters. With the defaults the block has a 256-bit data path, 16-beat bursts and a 1 GiB region starting at address zero.

Top module: `spill_fifo_ctrl`

## Requirements
- R1: After reset, in_ready_o is 1, and out_valid_o, awvalid_o, wvalid_o, arvalid_o and err_o are all 0.
- R2: While no data is held in external memory and the consumer accepts words, every input word reaches the output in order and no AW or AR handshake takes place.
- R3: Every write burst carries awlen_o = BURST_LEN-1, awsize_o = WORD_LOG2-3 and awburst_o = 2'b01 (incrementing). It has exactly BURST_LEN W beats, and wlast_o is 1 on the last of those beats and on no other beat.
- R4: The n-th write burst since reset (counting from 0) targets byte address (n mod S)*BURST_LEN*2^(WORD_LOG2-3), where S = 2^REGION_LOG2 / (BURST_LEN*2^(WORD_LOG2-3)). The n-th read burst uses the same formula, so the pointers wrap to zero at the end of the region.
- R5: Output words leave in exactly the order they were accepted, with no loss and no duplication. This holds for spilled data too. Once memory holds data, newer input words also pass through memory until memory drains.
- R6: A write burst starts only when the output queue is full, or memory already holds data, and the input queue holds at least BURST_LEN words. A read burst starts only when the output queue has room for BURST_LEN words.
- R7: At most S bursts are written but not yet read back. With the consumer stalled, the block accepts exactly IN_DEPTH+OUT_DEPTH+S*BURST_LEN words and then holds in_ready_o low.
- R8: A burst is read back only after its write response has been accepted on B.
- R9: Only one burst is outstanding per direction. No new AW is issued before the previous B is accepted, and no AR is issued while R beats of the previous read are still due.
- R10: A write response other than OKAY (bresp_i != 2'b00) sets err_o, which stays 1 until reset. The data stream is not disturbed.
- R11: Once awvalid_o or arvalid_o rises, it stays 1 and its address stays unchanged until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 2^WORD_LOG2 | Producer word |
| in_valid_i | input | 1 | Producer word valid |
| in_ready_o | output | 1 | Input queue can accept |
| out_data_o | output | 2^WORD_LOG2 | Consumer word |
| out_valid_o | output | 1 | Consumer word valid |
| out_ready_i | input | 1 | Consumer accepts |
| awaddr_o | output | AXI_AW | Write burst address |
| awlen_o | output | 8 | Write burst length minus one |
| awsize_o | output | 3 | Log2 of bytes per beat |
| awburst_o | output | 2 | Burst type (incrementing) |
| awvalid_o | output | 1 | Write address valid |
| awready_i | input | 1 | Write address ready |
| wdata_o | output | 2^WORD_LOG2 | Write beat data |
| wstrb_o | output | 2^(WORD_LOG2-3) | Byte enables, all set |
| wlast_o | output | 1 | Last beat of write burst |
| wvalid_o | output | 1 | Write beat valid |
| wready_i | input | 1 | Write beat ready |
| bresp_i | input | 2 | Write response code |
| bvalid_i | input | 1 | Write response valid |
| bready_o | output | 1 | Write response ready |
| araddr_o | output | AXI_AW | Read burst address |
| arlen_o | output | 8 | Read burst length minus one |
| arsize_o | output | 3 | Log2 of bytes per beat |
| arburst_o | output | 2 | Burst type (incrementing) |
| arvalid_o | output | 1 | Read address valid |
| arready_i | input | 1 | Read address ready |
| rdata_i | input | 2^WORD_LOG2 | Read beat data |
| rvalid_i | input | 1 | Read beat valid |
| rready_o | output | 1 | Read beat ready |
| err_o | output | 1 | Sticky bad write response flag |

## Verification
A write burst into the circular region can run in the same cycle as a read burst out of it. In that case a B acceptance and the final R beat of an earlier burst can land on the same edge, and both move the occupancy pointers at once. The bench provokes this by streaming continuously against a slow consumer. Its memory model adds random ready/valid gaps and a B delay that changes from burst to burst, so the two completions collide many times across several region wraps. The bench judges the result at the ports: each output word must equal the next value of the counting pattern. The model also checks the read address sequence and the rule that a read is issued only after its burst has been acknowledged.

// File: rtl/spill_pkg.sv
package spill_pkg;
  localparam logic [1:0] RESP_OKAY  = 2'b00;
  localparam logic [1:0] BURST_INCR = 2'b01;
endpackage

// File: rtl/spill_sync_fifo.sv
module spill_sync_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [AW:0]   count_o
);
  logic [W-1:0] mem_q [DEPTH];
  logic [AW:0]  wp_q, rp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (push_i) wp_q <= wp_q + 1'b1;
      if (pop_i)  rp_q <= rp_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q[AW-1:0]] <= data_i;
  end

  assign count_o = wp_q - rp_q;
  assign full_o  = (count_o == (AW+1)'(DEPTH));
  assign empty_o = (wp_q == rp_q);
  assign data_o  = mem_q[rp_q[AW-1:0]];

  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r5_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/spill_wr_eng.sv
module spill_wr_eng #(
  parameter int DATA_W    = 256,
  parameter int AXI_AW    = 32,
  parameter int BURST_LEN = 16,
  localparam int BW       = $clog2(BURST_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AXI_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              src_pop_o,
  output logic [AXI_AW-1:0] awaddr_o,
  output logic              awvalid_o,
  input  logic              awready_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic              wlast_o,
  output logic              wvalid_o,
  input  logic              wready_i,
  input  logic [1:0]        bresp_i,
  input  logic              bvalid_i,
  output logic              bready_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              bad_o
);
  import spill_pkg::*;

  logic          aw_pend_q, w_pend_q, b_pend_q;
  logic [BW-1:0] beat_q;
  logic [AXI_AW-1:0] addr_q;
  logic          w_hs, beat_last;

  assign w_hs      = wvalid_o && wready_i;
  assign beat_last = (beat_q == BW'(BURST_LEN-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aw_pend_q <= 1'b0;
      w_pend_q  <= 1'b0;
      b_pend_q  <= 1'b0;
      beat_q    <= '0;
      addr_q    <= '0;
    end else begin
      if (start_i) begin
        aw_pend_q <= 1'b1;
        w_pend_q  <= 1'b1;
        beat_q    <= '0;
        addr_q    <= addr_i;
      end else begin
        if (awvalid_o && awready_i) aw_pend_q <= 1'b0;
        if (w_hs) begin
          beat_q <= beat_q + 1'b1;
          if (beat_last) begin
            w_pend_q <= 1'b0;
            b_pend_q <= 1'b1;
          end
        end
        if (done_o) b_pend_q <= 1'b0;
      end
    end
  end

  assign awaddr_o  = addr_q;
  assign awvalid_o = aw_pend_q;
  assign wvalid_o  = w_pend_q;
  assign wdata_o   = src_data_i;
  assign wlast_o   = w_pend_q && beat_last;
  assign src_pop_o = w_hs;
  assign bready_o  = b_pend_q && !aw_pend_q;
  assign done_o    = bvalid_i && bready_o;
  assign bad_o     = done_o && (bresp_i != RESP_OKAY);
  assign busy_o    = aw_pend_q || w_pend_q || b_pend_q;

  a_r9_single_aw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
  a_r9_no_aw_while_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    awvalid_o |-> !bready_o);
  a_r11_aw_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (awvalid_o && !awready_i) |=> (awvalid_o && $stable(awaddr_o)));
endmodule

// File: rtl/spill_rd_eng.sv
module spill_rd_eng #(
  parameter int DATA_W    = 256,
  parameter int AXI_AW    = 32,
  parameter int BURST_LEN = 16,
  localparam int BW       = $clog2(BURST_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AXI_AW-1:0] addr_i,
  output logic [AXI_AW-1:0] araddr_o,
  output logic              arvalid_o,
  input  logic              arready_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              rvalid_i,
  output logic              rready_o,
  output logic              push_o,
  output logic [DATA_W-1:0] push_data_o,
  output logic              busy_o,
  output logic              done_o
);
  logic          ar_pend_q, r_pend_q;
  logic [BW-1:0] beat_q;
  logic [AXI_AW-1:0] addr_q;
  logic          beat_last;

  assign beat_last = (beat_q == BW'(BURST_LEN-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ar_pend_q <= 1'b0;
      r_pend_q  <= 1'b0;
      beat_q    <= '0;
      addr_q    <= '0;
    end else if (start_i) begin
      ar_pend_q <= 1'b1;
      r_pend_q  <= 1'b1;
      beat_q    <= '0;
      addr_q    <= addr_i;
    end else begin
      if (arvalid_o && arready_i) ar_pend_q <= 1'b0;
      if (push_o) begin
        beat_q <= beat_q + 1'b1;
        if (beat_last) r_pend_q <= 1'b0;
      end
    end
  end

  assign araddr_o    = addr_q;
  assign arvalid_o   = ar_pend_q;
  assign rready_o    = r_pend_q && !ar_pend_q;
  assign push_o      = rvalid_i && rready_o;
  assign push_data_o = rdata_i;
  assign done_o      = push_o && beat_last;
  assign busy_o      = ar_pend_q || r_pend_q;

  a_r9_no_ar_during_r: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arvalid_o |-> (beat_q == '0));
  a_r11_ar_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arvalid_o && !arready_i) |=> (arvalid_o && $stable(araddr_o)));
endmodule

// File: rtl/spill_fifo_ctrl.sv
module spill_fifo_ctrl #(
  parameter int WORD_LOG2   = 8,
  parameter int BURST_LEN   = 16,
  parameter int REGION_LOG2 = 30,
  parameter int AXI_AW      = 32,
  parameter int IN_DEPTH    = 32,
  parameter int OUT_DEPTH   = 32,
  localparam int DATA_W     = 1 << WORD_LOG2,
  localparam int BYTES_LOG2 = WORD_LOG2 - 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [DATA_W-1:0]        in_data_i,
  input  logic                     in_valid_i,
  output logic                     in_ready_o,
  output logic [DATA_W-1:0]        out_data_o,
  output logic                     out_valid_o,
  input  logic                     out_ready_i,
  output logic [AXI_AW-1:0]        awaddr_o,
  output logic [7:0]               awlen_o,
  output logic [2:0]               awsize_o,
  output logic [1:0]               awburst_o,
  output logic                     awvalid_o,
  input  logic                     awready_i,
  output logic [DATA_W-1:0]        wdata_o,
  output logic [(1<<BYTES_LOG2)-1:0] wstrb_o,
  output logic                     wlast_o,
  output logic                     wvalid_o,
  input  logic                     wready_i,
  input  logic [1:0]               bresp_i,
  input  logic                     bvalid_i,
  output logic                     bready_o,
  output logic [AXI_AW-1:0]        araddr_o,
  output logic [7:0]               arlen_o,
  output logic [2:0]               arsize_o,
  output logic [1:0]               arburst_o,
  output logic                     arvalid_o,
  input  logic                     arready_i,
  input  logic [DATA_W-1:0]        rdata_i,
  input  logic                     rvalid_i,
  output logic                     rready_o,
  output logic                     err_o
);
  import spill_pkg::*;

  localparam int BURST_LOG2  = $clog2(BURST_LEN);
  localparam int BB_LOG2     = BYTES_LOG2 + BURST_LOG2;
  localparam int SLOT_LOG2   = REGION_LOG2 - BB_LOG2;
  localparam int PTR_W       = SLOT_LOG2 + 1;
  localparam int PAD_W       = AXI_AW - REGION_LOG2;
  localparam int IN_CW       = $clog2(IN_DEPTH) + 1;
  localparam int OUT_CW      = $clog2(OUT_DEPTH) + 1;
  localparam logic [PTR_W-1:0]  SLOTS_P   = {1'b1, {SLOT_LOG2{1'b0}}};
  localparam logic [IN_CW-1:0]  BURST_IN  = IN_CW'(BURST_LEN);
  localparam logic [OUT_CW-1:0] ROOM_LIM  = OUT_CW'(OUT_DEPTH - BURST_LEN);

  // input queue
  logic              in_full, in_empty, in_pop;
  logic [IN_CW-1:0]  in_cnt;
  logic [DATA_W-1:0] in_head;
  // output queue
  logic              out_full, out_empty, out_push;
  logic [OUT_CW-1:0] out_cnt;
  logic [DATA_W-1:0] out_wdata;
  // control
  logic              spill_q, bypass_mv, enter_spill, leave_spill;
  logic              wr_start, rd_start, wr_busy, rd_busy;
  logic              wr_done, rd_done, wr_bad, w_pop, r_push;
  logic [DATA_W-1:0] r_data;
  logic [PTR_W-1:0]  wr_issue_q, wr_ack_q, rd_issue_q, rd_ret_q, occ;
  logic [AXI_AW-1:0] wr_addr, rd_addr;

  spill_sync_fifo #(.W(DATA_W), .DEPTH(IN_DEPTH)) u_in_q (
    .clk_i, .rst_ni,
    .push_i (in_valid_i && !in_full),
    .data_i (in_data_i),
    .pop_i  (in_pop),
    .data_o (in_head),
    .full_o (in_full),
    .empty_o(in_empty),
    .count_o(in_cnt)
  );

  spill_sync_fifo #(.W(DATA_W), .DEPTH(OUT_DEPTH)) u_out_q (
    .clk_i, .rst_ni,
    .push_i (out_push),
    .data_i (out_wdata),
    .pop_i  (out_valid_o && out_ready_i),
    .data_o (out_data_o),
    .full_o (out_full),
    .empty_o(out_empty),
    .count_o(out_cnt)
  );

  assign in_ready_o  = !in_full;
  assign out_valid_o = !out_empty;

  assign occ         = wr_issue_q - rd_ret_q;
  assign bypass_mv   = !spill_q && !in_empty && !out_full;
  assign enter_spill = !spill_q && out_full && (in_cnt >= BURST_IN);
  assign wr_start    = spill_q && !wr_busy && (in_cnt >= BURST_IN) && (occ != SLOTS_P);
  assign leave_spill = spill_q && (occ == '0) && !wr_start;
  assign rd_start    = !rd_busy && (wr_ack_q != rd_issue_q) && (out_cnt <= ROOM_LIM);

  assign in_pop    = bypass_mv || w_pop;
  assign out_push  = bypass_mv || r_push;
  assign out_wdata = bypass_mv ? in_head : r_data;

  assign wr_addr = {{PAD_W{1'b0}}, wr_issue_q[SLOT_LOG2-1:0], {BB_LOG2{1'b0}}};
  assign rd_addr = {{PAD_W{1'b0}}, rd_issue_q[SLOT_LOG2-1:0], {BB_LOG2{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spill_q    <= 1'b0;
      wr_issue_q <= '0;
      wr_ack_q   <= '0;
      rd_issue_q <= '0;
      rd_ret_q   <= '0;
      err_o      <= 1'b0;
    end else begin
      if (enter_spill)      spill_q <= 1'b1;
      else if (leave_spill) spill_q <= 1'b0;
      if (wr_start) wr_issue_q <= wr_issue_q + 1'b1;
      if (wr_done)  wr_ack_q   <= wr_ack_q + 1'b1;
      if (rd_start) rd_issue_q <= rd_issue_q + 1'b1;
      if (rd_done)  rd_ret_q   <= rd_ret_q + 1'b1;
      if (wr_bad)   err_o      <= 1'b1;
    end
  end

  spill_wr_eng #(.DATA_W(DATA_W), .AXI_AW(AXI_AW), .BURST_LEN(BURST_LEN)) u_wr (
    .clk_i, .rst_ni,
    .start_i   (wr_start),
    .addr_i    (wr_addr),
    .src_data_i(in_head),
    .src_pop_o (w_pop),
    .awaddr_o, .awvalid_o, .awready_i,
    .wdata_o, .wlast_o, .wvalid_o, .wready_i,
    .bresp_i, .bvalid_i, .bready_o,
    .busy_o    (wr_busy),
    .done_o    (wr_done),
    .bad_o     (wr_bad)
  );

  spill_rd_eng #(.DATA_W(DATA_W), .AXI_AW(AXI_AW), .BURST_LEN(BURST_LEN)) u_rd (
    .clk_i, .rst_ni,
    .start_i    (rd_start),
    .addr_i     (rd_addr),
    .araddr_o, .arvalid_o, .arready_i,
    .rdata_i, .rvalid_i, .rready_o,
    .push_o     (r_push),
    .push_data_o(r_data),
    .busy_o     (rd_busy),
    .done_o     (rd_done)
  );

  assign awlen_o   = 8'(BURST_LEN - 1);
  assign arlen_o   = 8'(BURST_LEN - 1);
  assign awsize_o  = 3'(BYTES_LOG2);
  assign arsize_o  = 3'(BYTES_LOG2);
  assign awburst_o = BURST_INCR;
  assign arburst_o = BURST_INCR;
  assign wstrb_o   = '1;

  // independent beat count for WLAST placement
  logic [BURST_LOG2:0] wb_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wb_seen_q <= '0;
    else if (wvalid_o && wready_i) wb_seen_q <= wlast_o ? '0 : wb_seen_q + 1'b1;
  end

  a_r3_wlast_on_final: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wvalid_o && wready_i && wlast_o) |-> (wb_seen_q == (BURST_LOG2+1)'(BURST_LEN-1)));
  a_r3_no_early_wlast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wvalid_o && wready_i && !wlast_o) |-> (wb_seen_q < (BURST_LOG2+1)'(BURST_LEN-1)));
  a_r5_bypass_mem_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_mv |-> (wr_issue_q == rd_ret_q));
  a_r5_w_has_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wvalid_o |-> !in_empty);
  a_r6_r_has_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_i && rready_o) |-> !out_full);
  a_r7_region_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= SLOTS_P);
  a_r8_read_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arvalid_o |-> (wr_ack_q != rd_ret_q));
  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

// File: tb/tb_spill_fifo_ctrl.sv
`timescale 1ns/1ps
module tb_spill_fifo_ctrl;
  localparam int WL = 5, BL = 16, RL = 8, IND = 32, OUTD = 32;
  localparam int DW = 1 << WL;
  localparam int BURST_BYTES = BL * (DW/8);
  localparam int SLOTS = (1 << RL) / BURST_BYTES;
  localparam int CAP = IND + OUTD + SLOTS*BL;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [DW-1:0] in_data = '0, out_data, wdata, rdata;
  logic in_valid = 0, in_ready, out_valid, out_ready = 0;
  logic [31:0] awaddr, araddr;
  logic [7:0] awlen, arlen;
  logic [2:0] awsize, arsize;
  logic [1:0] awburst, arburst, bresp;
  logic awvalid, awready, wlast, wvalid, wready, bvalid, bready;
  logic arvalid, arready, rvalid, rready, err;
  logic [DW/8-1:0] wstrb;

  spill_fifo_ctrl #(.WORD_LOG2(WL), .BURST_LEN(BL), .REGION_LOG2(RL), .AXI_AW(32),
                    .IN_DEPTH(IND), .OUT_DEPTH(OUTD)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_data_i(in_data), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .out_data_o(out_data), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .awaddr_o(awaddr), .awlen_o(awlen), .awsize_o(awsize), .awburst_o(awburst),
    .awvalid_o(awvalid), .awready_i(awready),
    .wdata_o(wdata), .wstrb_o(wstrb), .wlast_o(wlast), .wvalid_o(wvalid), .wready_i(wready),
    .bresp_i(bresp), .bvalid_i(bvalid), .bready_o(bready),
    .araddr_o(araddr), .arlen_o(arlen), .arsize_o(arsize), .arburst_o(arburst),
    .arvalid_o(arvalid), .arready_i(arready),
    .rdata_i(rdata), .rvalid_i(rvalid), .rready_o(rready), .err_o(err)
  );

  int n_chk = 0, n_fail = 0, tx = 0, rx = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      finish_run();
    end
  end

  // memory slave model
  logic [DW-1:0] mem [64];
  logic [7:0] lf;
  logic aw_have, b_pend, r_active, err_once, pv_aw, pv_ar;
  logic [5:0] w_base, r_base;
  logic [3:0] wbeat, rbeat;
  logic [31:0] pv_awaddr, pv_araddr;
  int bcnt, aw_count, ar_count, acked, tx_first_aw;

  assign awready = !aw_have && lf[0];
  assign wready  = aw_have && !b_pend && lf[1];
  assign bvalid  = b_pend && (bcnt == 0);
  assign bresp   = err_once ? 2'b10 : 2'b00;
  assign arready = !r_active && lf[2];
  assign rvalid  = r_active && lf[3];
  assign rdata   = mem[6'(r_base + 6'(rbeat))];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lf <= 8'hA5; aw_have <= 0; b_pend <= 0; r_active <= 0; pv_aw <= 0; pv_ar <= 0;
      wbeat <= 0; rbeat <= 0; bcnt <= 0; w_base <= 0; r_base <= 0;
      pv_awaddr <= 0; pv_araddr <= 0;
    end else begin
      lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      pv_aw <= awvalid && !awready; pv_awaddr <= awaddr;
      pv_ar <= arvalid && !arready; pv_araddr <= araddr;
      if (pv_aw) chk(awvalid && awaddr == pv_awaddr, "R11 aw hold", int'(awaddr), int'(pv_awaddr));
      if (pv_ar) chk(arvalid && araddr == pv_araddr, "R11 ar hold", int'(araddr), int'(pv_araddr));
      if (awvalid && aw_have) chk(0, "R9 aw before b", 1, 0);
      if (arvalid && r_active) chk(0, "R9 ar during r", 1, 0);
      if (awvalid && awready) begin
        chk(awaddr == 32'((aw_count % SLOTS) * BURST_BYTES), "R4 aw addr",
            int'(awaddr), (aw_count % SLOTS) * BURST_BYTES);
        chk(awlen == 8'(BL-1) && awsize == 3'(WL-3) && awburst == 2'b01, "R3 aw fields",
            int'({awlen, awsize, awburst}), int'({8'(BL-1), 3'(WL-3), 2'b01}));
        if (aw_count == 0) tx_first_aw <= tx;
        aw_count <= aw_count + 1;
        aw_have <= 1; w_base <= awaddr[7:2]; wbeat <= 0;
      end
      if (wvalid && wready) begin
        mem[6'(w_base + 6'(wbeat))] <= wdata;
        chk(wlast == (wbeat == 4'(BL-1)), "R3 wlast", int'(wlast), int'(wbeat == 4'(BL-1)));
        wbeat <= wbeat + 1;
        if (wbeat == 4'(BL-1)) begin b_pend <= 1; bcnt <= aw_count % 4; end
      end
      if (b_pend && bcnt != 0) bcnt <= bcnt - 1;
      if (bvalid && bready) begin
        aw_have <= 0; b_pend <= 0; acked <= acked + 1; err_once <= 0;
      end
      if (arvalid && arready) begin
        chk(ar_count < acked, "R8 read after ack", ar_count, acked);
        chk(araddr == 32'((ar_count % SLOTS) * BURST_BYTES), "R4 ar addr",
            int'(araddr), (ar_count % SLOTS) * BURST_BYTES);
        ar_count <= ar_count + 1;
        r_active <= 1; r_base <= araddr[7:2]; rbeat <= 0;
      end
      if (rvalid && rready) begin
        rbeat <= rbeat + 1;
        if (rbeat == 4'(BL-1)) r_active <= 0;
      end
    end
  end

  // consumer monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      chk(out_data == DW'(rx), "R5 order", int'(out_data), rx);
      rx++;
    end
  end

  task automatic push_n(input int n, input int guard);
    int sent = 0;
    int g = 0;
    while (sent < n && g < guard) begin
      @(negedge clk);
      in_valid = 1; in_data = DW'(tx);
      if (in_ready) begin sent++; tx++; end
      g++;
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wait_rx(input int target, input int guard);
    int g = 0;
    while (rx < target && g < guard) begin @(negedge clk); g++; end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(in_ready == 1, "R1 in_ready", int'(in_ready), 1);
    chk(!out_valid && !awvalid && !wvalid && !arvalid, "R1 valids",
        int'({out_valid, awvalid, wvalid, arvalid}), 0);
    chk(err == 0, "R1 err", int'(err), 0);
  endtask

  task automatic t_bypass();
    int aw0 = aw_count, ar0 = ar_count;
    out_ready = 1;
    push_n(100, 2000);
    wait_rx(tx, 500);
    chk(rx == 100, "R2 bypass count", rx, 100);
    chk(aw_count == aw0 && ar_count == ar0, "R2 no memory traffic", aw_count + ar_count, aw0 + ar0);
  endtask

  task automatic t_fill_drain();
    int t0 = tx, aw0 = aw_count;
    int extra;
    out_ready = 0;
    push_n(CAP, 4000);
    chk(tx - t0 == CAP, "R7 accepted to capacity", tx - t0, CAP);
    chk(aw_count - aw0 == SLOTS, "R7 bursts when full", aw_count - aw0, SLOTS);
    chk(tx_first_aw - t0 >= OUTD + BL, "R6 first write needs full queues", tx_first_aw - t0, OUTD + BL);
    extra = tx;
    push_n(1, 40);
    chk(tx == extra, "R7 in_ready low when full", tx - extra, 0);
    repeat (3) @(negedge clk);
    chk(in_ready == 0, "R7 in_ready", int'(in_ready), 0);
    out_ready = 1;
    wait_rx(tx, 4000);
    chk(rx == tx, "R5 drained all spilled words", rx, tx);
    chk(aw_count - aw0 == SLOTS + (tx - t0 - CAP + IND) / BL, "R5 queued input went through memory",
        aw_count - aw0, SLOTS + IND / BL);
  endtask

  task automatic t_stream();
    int target = tx + 600;
    fork
      push_n(600, 20000);
      begin
        int k = 0;
        while (rx < target && k < 20000) begin
          @(negedge clk);
          out_ready = (k % 3 == 0);
          k++;
        end
        out_ready = 1;
      end
    join
    wait_rx(target, 2000);
    chk(rx == target, "R5 streamed count", rx, target);
    chk(aw_count > 3 * SLOTS, "R4 wrapped region", aw_count, 3 * SLOTS);
    chk(err == 0, "R10 err clear on OKAY", int'(err), 0);
  endtask

  task automatic t_error();
    int aw0 = aw_count;
    err_once = 1;
    out_ready = 0;
    push_n(OUTD + IND + BL, 3000);
    repeat (60) @(negedge clk);
    chk(aw_count > aw0, "R10 burst issued", aw_count, aw0 + 1);
    chk(err == 1, "R10 err set", int'(err), 1);
    out_ready = 1;
    wait_rx(tx, 4000);
    chk(rx == tx, "R10 stream intact", rx, tx);
    chk(err == 1, "R10 err sticky", int'(err), 1);
  endtask

  initial begin
    err_once = 0; aw_count = 0; ar_count = 0; acked = 0; tx_first_aw = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_bypass();
    t_fill_drain();
    t_stream();
    t_error();
    finish_run();
  end
endmodule